// File: doc/BRIEF.md
# Serial Receiver Status Flag Controller

This block keeps the receive-side status of an asynchronous serial port. It holds four flags: data-full, idle-line, overrun and noise. It also owns the receive data holding register. A frame-complete pulse from the receive shifter moves the shifter's parallel word into the holding register, unless that register still holds unread data. In that case the new word is dropped and an overrun is recorded. The noise indication that comes with an accepted frame is latched beside the data.

The idle-line flag is driven by a count of consecutive high bit times, taken on a per-bit-time strobe. The length of the run it needs depends on the frame-length select. Idle detection is re-armed only by an accepted frame, and it is held off while the receiver is in wake-up mode.

Software clears the flags only through two-step bus sequences:
- a status read followed by a data read clears data-full;
- a status read followed by a status write clears overrun and noise.

Top module: `rx_flag_ctrl`

## Requirements
- R1: The status word carries data-full at bit 13, idle at bit 12, overrun at bit 11 and noise at bit 10. Every other bit reads 0.
- R2: A frame-complete pulse while data-full is 0 loads the frame word into the holding register and sets data-full on the next cycle.
- R3: Data-full clears only on a data read that comes after a status read made while data-full was 1. A status write in between does not cancel the sequence. A data read with no such earlier status read leaves the flag set, and so does a data read after a status read made while the flag was 0.
- R4: A frame-complete pulse while data-full is 1 sets overrun. The holding register keeps its old value.
- R5: The noise flag sets together with data-full when an accepted frame carries the noise indication. A frame that causes an overrun never sets noise.
- R6: Overrun and noise each clear on a status write that comes after a status read made while that flag was 1. A data read in between does not cancel the sequence. A status write with no such earlier read leaves them set.
- R7: Once armed, the idle flag sets on the 10th consecutive high bit time when frame-length select is 0, and on the 11th when it is 1. It stays 0 one bit time earlier.
- R8: A bit time with the line low clears the idle flag. After that, the flag does not set again, however long the line stays high, until a frame has been accepted.
- R9: While wake-up mode is 1, the idle flag does not set. Once wake-up mode drops, the next high bit time sets it if the high run has already reached the limit.
- R10: After reset, all flags, the holding register and the status word are 0. The idle flag stays unarmed until the first accepted frame.
- R11: If a flag sets in the same cycle that its clear sequence completes, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_done | input | 1 | One-cycle pulse: the shifter has completed a frame |
| frame_noise | input | 1 | Noise was seen on the frame that completes with frame_done |
| frame_data | input | DATA_W | Parallel word from the shifter |
| bit_tick | input | 1 | One-cycle strobe, once per bit time |
| line_level | input | 1 | Sampled receive line level, valid with bit_tick |
| long_frame | input | 1 | Frame-length select (1 = long frame) |
| wake_mode | input | 1 | Receiver wake-up mode |
| rd_status | input | 1 | Bus read of the status word |
| rd_data | input | 1 | Bus read of the data register |
| wr_status | input | 1 | Bus write of the status word |
| status_word | output | 16 | Status flags |
| rx_data | output | DATA_W | Receive data holding register |

## Verification
A wrong arm bit in one of the clear sequences is invisible at first. It shows on the next data read or status write, where a flag either survives a complete sequence or drops without one. A wrong idle counter or idle arm shows on the bit tick where the 10- or 11-tick limit is reached, one cycle after that tick. A wrong data-full state shows on the very next frame pulse, either as a spurious overrun or as held data that gets overwritten. The directed scenarios therefore check the status word one cycle after each strobe, and they also probe one step before and one step after each limit.

// File: rtl/rx_flag_pkg.sv
`timescale 1ns/1ps
package rx_flag_pkg;
  localparam int STAT_W    = 16;
  localparam int FULL_BIT  = 13;
  localparam int IDLE_BIT  = 12;
  localparam int OVR_BIT   = 11;
  localparam int NOISE_BIT = 10;

  // indices of the flags that are cleared through a bus sequence
  localparam int SEQ_FULL  = 0;
  localparam int SEQ_OVR   = 1;
  localparam int SEQ_NOISE = 2;
  localparam int SEQ_N     = 3;

  function automatic logic [STAT_W-1:0] pack_status(input logic full,
                                                     input logic idle,
                                                     input logic ovr,
                                                     input logic noise);
    logic [STAT_W-1:0] w;
    w            = '0;
    w[FULL_BIT]  = full;
    w[IDLE_BIT]  = idle;
    w[OVR_BIT]   = ovr;
    w[NOISE_BIT] = noise;
    return w;
  endfunction

  function automatic int unsigned idle_limit(input logic long_sel,
                                             input int unsigned short_run,
                                             input int unsigned long_run);
    return long_sel ? long_run : short_run;
  endfunction
endpackage

// File: rtl/rx_clr_seq.sv
`timescale 1ns/1ps
// Two-step clear: a status read while the flag is set arms the sequence,
// and a later completing strobe fires the clear.
module rx_clr_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  input  logic arm_strobe,
  input  logic fire_strobe,
  output logic clear
);
  logic arm_q;

  assign clear = arm_q & fire_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  arm_q <= 1'b0;
    else if (clear)              arm_q <= 1'b0;
    else if (arm_strobe && flag) arm_q <= 1'b1;
  end
endmodule

// File: rtl/rx_idle_det.sv
`timescale 1ns/1ps
module rx_idle_det #(
  parameter int unsigned IDLE_SHORT = 10,
  parameter int unsigned IDLE_LONG  = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic line_level,
  input  logic long_frame,
  input  logic wake_mode,
  input  logic frame_accept,
  output logic idle_flag,
  output logic idle_set_evt,
  output logic idle_armed
);
  import rx_flag_pkg::*;

  localparam int CNT_W = $clog2(IDLE_LONG + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_LONG);

  logic [CNT_W-1:0] cnt_q, cnt_inc, limit;
  logic             idle_q, arm_q;
  logic             high_tick, low_tick;

  assign high_tick = bit_tick & line_level;
  assign low_tick  = bit_tick & ~line_level;
  assign cnt_inc   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign limit     = CNT_W'(idle_limit(long_frame, IDLE_SHORT, IDLE_LONG));

  assign idle_set_evt = high_tick & (cnt_inc >= limit) & arm_q & ~wake_mode & ~idle_q;
  assign idle_flag    = idle_q;
  assign idle_armed   = arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idle_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (low_tick)       cnt_q <= '0;
      else if (high_tick) cnt_q <= cnt_inc;

      if (low_tick)          idle_q <= 1'b0;
      else if (idle_set_evt) idle_q <= 1'b1;

      if (frame_accept)      arm_q <= 1'b1;
      else if (idle_set_evt) arm_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_hold_reg.sv
`timescale 1ns/1ps
module rx_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/rx_flag_ctrl.sv
`timescale 1ns/1ps
module rx_flag_ctrl #(
  parameter int          DATA_W     = 8,
  parameter int unsigned IDLE_SHORT = 10,
  parameter int unsigned IDLE_LONG  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic              frame_noise,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              bit_tick,
  input  logic              line_level,
  input  logic              long_frame,
  input  logic              wake_mode,
  input  logic              rd_status,
  input  logic              rd_data,
  input  logic              wr_status,
  output logic [15:0]       status_word,
  output logic [DATA_W-1:0] rx_data
);
  import rx_flag_pkg::*;

  logic             full_q, ovr_q, noise_q;
  logic             accept_evt, overrun_evt;
  logic             idle_flag, idle_set_evt, idle_armed;
  logic [SEQ_N-1:0] seq_flag, seq_fire, seq_clr;

  assign accept_evt  = frame_done & ~full_q;
  assign overrun_evt = frame_done & full_q;

  assign seq_flag[SEQ_FULL]  = full_q;
  assign seq_flag[SEQ_OVR]   = ovr_q;
  assign seq_flag[SEQ_NOISE] = noise_q;
  assign seq_fire[SEQ_FULL]  = rd_data;
  assign seq_fire[SEQ_OVR]   = wr_status;
  assign seq_fire[SEQ_NOISE] = wr_status;

  for (genvar g = 0; g < SEQ_N; g++) begin : g_seq
    rx_clr_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .flag       (seq_flag[g]),
      .arm_strobe (rd_status),
      .fire_strobe(seq_fire[g]),
      .clear      (seq_clr[g])
    );
  end

  // set has priority over a completing clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
      noise_q <= 1'b0;
    end else begin
      if (accept_evt)             full_q <= 1'b1;
      else if (seq_clr[SEQ_FULL]) full_q <= 1'b0;

      if (overrun_evt)            ovr_q <= 1'b1;
      else if (seq_clr[SEQ_OVR])  ovr_q <= 1'b0;

      if (accept_evt && frame_noise) noise_q <= 1'b1;
      else if (seq_clr[SEQ_NOISE])   noise_q <= 1'b0;
    end
  end

  rx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept_evt),
    .din  (frame_data),
    .dout (rx_data)
  );

  rx_idle_det #(.IDLE_SHORT(IDLE_SHORT), .IDLE_LONG(IDLE_LONG)) u_idle (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .line_level  (line_level),
    .long_frame  (long_frame),
    .wake_mode   (wake_mode),
    .frame_accept(accept_evt),
    .idle_flag   (idle_flag),
    .idle_set_evt(idle_set_evt),
    .idle_armed  (idle_armed)
  );

  assign status_word = pack_status(full_q, idle_flag, ovr_q, noise_q);
endmodule

// File: rtl/rx_flag_ctrl_chk.sv
`timescale 1ns/1ps
module rx_flag_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_tick,
  input logic              line_level,
  input logic              wake_mode,
  input logic              rd_data,
  input logic              wr_status,
  input logic              accept_evt,
  input logic              overrun_evt,
  input logic              idle_set_evt,
  input logic              idle_armed,
  input logic [15:0]       status_word,
  input logic [DATA_W-1:0] rx_data
);
  import rx_flag_pkg::*;

  localparam logic [15:0] USED = pack_status(1'b1, 1'b1, 1'b1, 1'b1);

  p_unused_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word & ~USED) == 16'h0);

  p_accept_sets_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> status_word[FULL_BIT]);

  p_full_needs_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[FULL_BIT] && !rd_data) |=> status_word[FULL_BIT]);

  p_overrun_keeps_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> (status_word[OVR_BIT] && $stable(rx_data)));

  p_no_noise_on_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_evt && !status_word[NOISE_BIT]) |=> !status_word[NOISE_BIT]);

  p_or_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[OVR_BIT] && !wr_status) |=> status_word[OVR_BIT]);

  p_idle_only_on_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_word[IDLE_BIT] && !(bit_tick && line_level)) |=> !status_word[IDLE_BIT]);

  p_low_clears_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !line_level) |=> !status_word[IDLE_BIT]);

  p_idle_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idle_set_evt |-> idle_armed);

  p_wake_blocks_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_mode && !status_word[IDLE_BIT]) |=> !status_word[IDLE_BIT]);
endmodule

bind rx_flag_ctrl rx_flag_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_tick    (bit_tick),
  .line_level  (line_level),
  .wake_mode   (wake_mode),
  .rd_data     (rd_data),
  .wr_status   (wr_status),
  .accept_evt  (accept_evt),
  .overrun_evt (overrun_evt),
  .idle_set_evt(idle_set_evt),
  .idle_armed  (idle_armed),
  .status_word (status_word),
  .rx_data     (rx_data)
);

// File: tb/test_rx_flag_ctrl.sv
`timescale 1ns/1ps
module test_rx_flag_ctrl;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frame_done = 1'b0, frame_noise = 1'b0;
  logic [DATA_W-1:0] frame_data = '0;
  logic              bit_tick = 1'b0, line_level = 1'b1;
  logic              long_frame = 1'b0, wake_mode = 1'b0;
  logic              rd_status = 1'b0, rd_data = 1'b0, wr_status = 1'b0;
  logic [15:0]       status_word;
  logic [DATA_W-1:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rx_flag_ctrl #(.DATA_W(DATA_W)) i_rx_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_noise(frame_noise),
    .frame_data(frame_data), .bit_tick(bit_tick), .line_level(line_level),
    .long_frame(long_frame), .wake_mode(wake_mode), .rd_status(rd_status),
    .rd_data(rd_data), .wr_status(wr_status), .status_word(status_word),
    .rx_data(rx_data)
  );

  // expected status word, built from R1 bit positions
  function automatic logic [15:0] sw(input bit full, input bit idle,
                                     input bit ovr, input bit noise);
    return (16'(full) << 13) | (16'(idle) << 12) | (16'(ovr) << 11) | (16'(noise) << 10);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; outputs are settled at the following negedge
  task automatic cyc(input bit fd, input bit fn, input logic [DATA_W-1:0] d,
                     input bit rs, input bit rd, input bit ws);
    @(negedge clk);
    frame_done = fd; frame_noise = fn; frame_data = d;
    rd_status = rs; rd_data = rd; wr_status = ws;
    @(negedge clk);
    frame_done = 0; frame_noise = 0; rd_status = 0; rd_data = 0; wr_status = 0;
  endtask

  task automatic frame(input logic [DATA_W-1:0] d, input bit fn);
    cyc(1, fn, d, 0, 0, 0);
  endtask

  task automatic ticks(input bit lvl, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_tick = 1; line_level = lvl;
      @(negedge clk);
      bit_tick = 0; line_level = 1;
    end
  endtask

  task automatic clear_full();
    cyc(0, 0, '0, 1, 0, 0);
    cyc(0, 0, '0, 0, 1, 0);
  endtask

  task automatic t_reset();
    check(status_word, 16'h0, "R10 status after reset");
    check(rx_data, 0, "R10 data after reset");
    ticks(1, 12);
    check(status_word[12], 0, "R10 idle unarmed before first frame");
  endtask

  task automatic t_receive();
    frame(8'hA5, 0);
    check(status_word, sw(1, 0, 0, 0), "R1 R2 full at bit 13");
    check(rx_data, 8'hA5, "R2 data loaded");
  endtask

  task automatic t_full_clear();
    cyc(0, 0, '0, 0, 1, 0);
    check(status_word[13], 1, "R3 data read alone keeps full");
    cyc(0, 0, '0, 1, 0, 0);
    cyc(0, 0, '0, 0, 0, 1);
    check(status_word[13], 1, "R3 status write does not clear full");
    cyc(0, 0, '0, 0, 1, 0);
    check(status_word[13], 0, "R3 read-status then read-data clears");
    cyc(0, 0, '0, 1, 0, 0);
    frame(8'h3C, 0);
    cyc(0, 0, '0, 0, 1, 0);
    check(status_word[13], 1, "R3 status read while clear does not arm");
    check(rx_data, 8'h3C, "R2 second frame loaded");
    clear_full();
    check(status_word, 16'h0, "R3 cleared");
  endtask

  task automatic t_overrun();
    frame(8'h11, 0);
    frame(8'h22, 1);
    check(status_word, sw(1, 0, 1, 0), "R4 R5 overrun set, noise not set");
    check(rx_data, 8'h11, "R4 held data kept");
    cyc(0, 0, '0, 0, 0, 1);
    check(status_word[11], 1, "R6 write alone keeps overrun");
    cyc(0, 0, '0, 1, 0, 0);
    cyc(0, 0, '0, 0, 1, 0);
    check(status_word, sw(0, 0, 1, 0), "R6 data read between does not disarm");
    cyc(0, 0, '0, 0, 0, 1);
    check(status_word, 16'h0, "R6 overrun cleared");
  endtask

  task automatic t_noise();
    frame(8'h33, 1);
    check(status_word, sw(1, 0, 0, 1), "R5 noise with full");
    cyc(0, 0, '0, 1, 0, 0);
    cyc(0, 0, '0, 0, 0, 1);
    check(status_word, sw(1, 0, 0, 0), "R6 noise cleared");
    cyc(0, 0, '0, 0, 1, 0);
    check(status_word, 16'h0, "R3 full cleared after write between");
  endtask

  task automatic t_set_wins();
    frame(8'h44, 0);
    frame(8'h55, 0);
    cyc(0, 0, '0, 1, 0, 0);
    cyc(1, 0, 8'h56, 0, 0, 1);
    check(status_word[11], 1, "R11 overrun set wins over clear");
    cyc(0, 0, '0, 1, 0, 0);
    cyc(0, 0, '0, 0, 0, 1);
    cyc(0, 0, '0, 0, 1, 0);
    check(status_word, 16'h0, "R6 overrun cleared after set-win");
    frame(8'h66, 1);
    cyc(0, 0, '0, 1, 0, 0);
    cyc(0, 0, '0, 0, 1, 0);
    cyc(1, 1, 8'h77, 0, 0, 1);
    check(status_word, sw(1, 0, 0, 1), "R11 noise set wins over clear");
    check(rx_data, 8'h77, "R2 frame during write loaded");
    cyc(0, 0, '0, 1, 0, 0);
    cyc(0, 0, '0, 0, 0, 1);
    cyc(0, 0, '0, 0, 1, 0);
    check(status_word, 16'h0, "R6 cleanup");
  endtask

  task automatic t_idle_short();
    long_frame = 0;
    ticks(0, 1);
    ticks(1, 9);
    check(status_word[12], 0, "R7 no idle after 9 highs");
    ticks(1, 1);
    check(status_word, sw(0, 1, 0, 0), "R1 R7 idle at bit 12 after 10");
  endtask

  task automatic t_idle_rearm();
    ticks(0, 1);
    check(status_word[12], 0, "R8 low clears idle");
    ticks(1, 12);
    check(status_word[12], 0, "R8 no idle without new frame");
  endtask

  task automatic t_idle_long();
    long_frame = 1;
    frame(8'h88, 0);
    clear_full();
    ticks(0, 1);
    ticks(1, 10);
    check(status_word[12], 0, "R7 long: no idle after 10");
    ticks(1, 1);
    check(status_word[12], 1, "R7 long: idle after 11");
  endtask

  task automatic t_wake();
    ticks(0, 1);
    frame(8'h99, 0);
    clear_full();
    wake_mode = 1;
    ticks(1, 12);
    check(status_word[12], 0, "R9 wake blocks idle");
    wake_mode = 0;
    ticks(1, 1);
    check(status_word[12], 1, "R9 idle after wake drops");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_receive();
    t_full_clear();
    t_overrun();
    t_noise();
    t_set_wins();
    t_idle_short();
    t_idle_rearm();
    t_idle_long();
    t_wake();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule